// File: doc/BRIEF.md
# Check Message Store with Diagonal Side Queues

This block holds check-to-variable messages for a layered min-sum decoder. Each check row is kept as one compressed record: the smallest and second-smallest magnitudes, the edge position of the smallest, and one sign bit for each edge of the row. A normal read rebuilds the message for any edge of a row from that record.

When a sub-matrix carries two diagonals, a compressed record cannot protect one diagonal's message while the other is rewritten. Messages on those two diagonals therefore go to two small side queues, one per diagonal. Each queue has its own push enable. The decoder pushes the second-diagonal message on the first pass of a repeated layer and the first-diagonal message only on the repeat pass. A diagonal read pops the matching queue in arrival order. Side storage grows with the number of double-diagonal sub-matrices and the lane count: with 45 lanes and four such sub-matrices, the two queues together hold 360 messages.

Both the write port and the read-request port are valid/ready streams. Neither port ever applies back-pressure, so `wr_ready` and `rd_req_ready` are held high after reset. The response has no ready: `rd_rsp_valid` pulses for one cycle, one cycle after each accepted request, and the consumer must take the data in that cycle. A push into a full queue or a pop from an empty queue is dropped and sets that queue's error flag. The flag stays set until reset.

Top module: `cmsg_store`

## Requirements
- R1: After reset, `rd_rsp_valid` is 0, `rd_rsp_data` is 0, both error flags are 0, both queues are empty, and both ready outputs are 1.
- R2: A read with `rd_mode` 2'b00 (normal) or 2'b11 (treated as normal), for an edge that differs from the stored minimum position, returns the stored minimum magnitude. The result is negated in two's complement when that edge's sign bit (bit `rd_edge` of the stored signs) is 1.
- R3: A normal read for the edge equal to the stored minimum position returns the second minimum magnitude, with that edge's sign applied in the same way.
- R4: Each accepted request gives `rd_rsp_valid` high on exactly the next cycle, with the data in that cycle. In every cycle without a response, `rd_rsp_valid` is 0 and `rd_rsp_data` is 0.
- R5: A read with `rd_mode` 2'b01 pops the first-diagonal queue and returns its messages in push order.
- R6: A read with `rd_mode` 2'b10 pops the second-diagonal queue in push order. The two queues are independent of each other.
- R7: A write with a diagonal enable low leaves that queue unchanged, while the compressed record is still written.
- R8: A push into a full queue is dropped and sets that queue's error flag. The messages already in the queue stay intact.
- R9: A diagonal read from an empty queue returns 0 with `rd_rsp_valid` high and sets that queue's error flag.
- R10: An error flag, once set, stays at 1 until reset, whatever traffic follows.
- R11: When a read and a write target the same row in the same cycle, the read returns the record that was stored before that write.
- R12: Rows are independent: a write to one row does not change the result of a normal read of another row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Row write request |
| wr_ready | output | 1 | Write accepted (always 1 after reset) |
| wr_row | input | ROW_W | Row written |
| wr_min1 | input | MAG_W | Smallest magnitude |
| wr_min2 | input | MAG_W | Second-smallest magnitude |
| wr_min_pos | input | EDGE_W | Edge position of the smallest magnitude |
| wr_signs | input | DEG | Sign bit of each edge (bit e belongs to edge e) |
| wr_d1_en | input | 1 | Push `wr_d1_msg` into the first-diagonal queue |
| wr_d1_msg | input | MSG_W | First-diagonal message, two's complement |
| wr_d2_en | input | 1 | Push `wr_d2_msg` into the second-diagonal queue |
| wr_d2_msg | input | MSG_W | Second-diagonal message, two's complement |
| rd_req_valid | input | 1 | Read request |
| rd_req_ready | output | 1 | Read accepted (always 1 after reset) |
| rd_row | input | ROW_W | Row read in normal mode |
| rd_edge | input | EDGE_W | Edge read in normal mode |
| rd_mode | input | 2 | 00 normal, 01 first diagonal, 10 second diagonal, 11 normal |
| rd_rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rd_rsp_data | output | MSG_W | Old message, two's complement |
| err_d1 | output | 1 | Sticky first-queue overflow or underflow |
| err_d2 | output | 1 | Sticky second-queue overflow or underflow |

## Verification
The assertions assume that the request inputs are 0 during reset, so an error flag can rise only from a push or pop in the cycle before. They also assume that the consumer never stalls the response, because the block has no response ready. The bench drives every input at the falling edge and releases the valid signals after one cycle. It keeps all requests low while reset is applied. It reaches the full and empty queue conditions only on purpose, in the scenarios that test the error flags.

// File: rtl/cmsg_pkg.sv
package cmsg_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_DIAG1  = 2'b01,
    MODE_DIAG2  = 2'b10,
    MODE_RSVD   = 2'b11
  } rd_mode_e;

  localparam int unsigned N_DIAG = 2;
endpackage

// File: rtl/cmsg_row_store.sv
module cmsg_row_store #(
  parameter int unsigned ROWS  = 16,
  parameter int unsigned DEG   = 8,
  parameter int unsigned MAG_W = 5,
  localparam int unsigned ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int unsigned EDGE_W = (DEG > 1) ? $clog2(DEG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ROW_W-1:0]  waddr,
  input  logic [MAG_W-1:0]  wmin1,
  input  logic [MAG_W-1:0]  wmin2,
  input  logic [EDGE_W-1:0] wpos,
  input  logic [DEG-1:0]    wsigns,
  input  logic [ROW_W-1:0]  raddr,
  output logic [MAG_W-1:0]  rmin1,
  output logic [MAG_W-1:0]  rmin2,
  output logic [EDGE_W-1:0] rpos,
  output logic [DEG-1:0]    rsigns
);
  logic [MAG_W-1:0]  min1_q  [ROWS];
  logic [MAG_W-1:0]  min2_q  [ROWS];
  logic [EDGE_W-1:0] pos_q   [ROWS];
  logic [DEG-1:0]    signs_q [ROWS];

  // Each row is a separate register.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        min1_q[r]  <= '0;
        min2_q[r]  <= '0;
        pos_q[r]   <= '0;
        signs_q[r] <= '0;
      end else if (we && (waddr == ROW_W'(r))) begin
        min1_q[r]  <= wmin1;
        min2_q[r]  <= wmin2;
        pos_q[r]   <= wpos;
        signs_q[r] <= wsigns;
      end
    end
  end

  // The read is combinational, so it returns the value stored before a write in the same cycle.
  always_comb begin
    rmin1  = min1_q[raddr];
    rmin2  = min2_q[raddr];
    rpos   = pos_q[raddr];
    rsigns = signs_q[raddr];
  end
endmodule

// File: rtl/cmsg_expand.sv
module cmsg_expand #(
  parameter int unsigned DEG   = 8,
  parameter int unsigned MAG_W = 5,
  localparam int unsigned EDGE_W = (DEG > 1) ? $clog2(DEG) : 1,
  localparam int unsigned MSG_W  = MAG_W + 1
) (
  input  logic [MAG_W-1:0]  min1,
  input  logic [MAG_W-1:0]  min2,
  input  logic [EDGE_W-1:0] pos,
  input  logic [DEG-1:0]    signs,
  input  logic [EDGE_W-1:0] edge_sel,
  output logic [MSG_W-1:0]  msg
);
  logic [MAG_W-1:0] mag;
  logic             neg;
  logic [MSG_W-1:0] unsigned_msg;

  always_comb begin
    mag          = (edge_sel == pos) ? min2 : min1;
    // A shifted mask keeps an edge index beyond the degree from selecting a sign bit.
    neg          = |(signs & (DEG'(1) << edge_sel));
    unsigned_msg = {1'b0, mag};
    msg          = neg ? (~unsigned_msg + MSG_W'(1)) : unsigned_msg;
  end
endmodule

// File: rtl/cmsg_diag_fifo.sv
module cmsg_diag_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 6,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         err
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          full;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      err    <= 1'b0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
      if ((push && full) || (pop && empty)) err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= push_data;
  end
endmodule

// File: rtl/cmsg_store.sv
module cmsg_store
  import cmsg_pkg::*;
#(
  parameter int unsigned ROWS     = 16,
  parameter int unsigned DEG      = 8,
  parameter int unsigned MAG_W    = 5,
  parameter int unsigned D1_DEPTH = 8,
  parameter int unsigned D2_DEPTH = 8,
  localparam int unsigned ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int unsigned EDGE_W = (DEG > 1) ? $clog2(DEG) : 1,
  localparam int unsigned MSG_W  = MAG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [MAG_W-1:0]  wr_min1,
  input  logic [MAG_W-1:0]  wr_min2,
  input  logic [EDGE_W-1:0] wr_min_pos,
  input  logic [DEG-1:0]    wr_signs,
  input  logic              wr_d1_en,
  input  logic [MSG_W-1:0]  wr_d1_msg,
  input  logic              wr_d2_en,
  input  logic [MSG_W-1:0]  wr_d2_msg,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [EDGE_W-1:0] rd_edge,
  input  logic [1:0]        rd_mode,
  output logic              rd_rsp_valid,
  output logic [MSG_W-1:0]  rd_rsp_data,
  output logic              err_d1,
  output logic              err_d2
);
  rd_mode_e mode;
  assign mode = rd_mode_e'(rd_mode);

  logic [MAG_W-1:0]  r_min1, r_min2;
  logic [EDGE_W-1:0] r_pos;
  logic [DEG-1:0]    r_signs;
  logic [MSG_W-1:0]  norm_msg;

  logic [N_DIAG-1:0] q_push, q_pop, q_empty, q_err;
  logic [MSG_W-1:0]  q_in   [N_DIAG];
  logic [MSG_W-1:0]  q_head [N_DIAG];

  cmsg_row_store #(.ROWS(ROWS), .DEG(DEG), .MAG_W(MAG_W)) rows_i (
    .clk(clk), .rst_n(rst_n),
    .we(wr_valid), .waddr(wr_row),
    .wmin1(wr_min1), .wmin2(wr_min2), .wpos(wr_min_pos), .wsigns(wr_signs),
    .raddr(rd_row),
    .rmin1(r_min1), .rmin2(r_min2), .rpos(r_pos), .rsigns(r_signs)
  );

  cmsg_expand #(.DEG(DEG), .MAG_W(MAG_W)) expand_i (
    .min1(r_min1), .min2(r_min2), .pos(r_pos), .signs(r_signs),
    .edge_sel(rd_edge), .msg(norm_msg)
  );

  assign q_push[0] = wr_valid && wr_d1_en;
  assign q_push[1] = wr_valid && wr_d2_en;
  assign q_in[0]   = wr_d1_msg;
  assign q_in[1]   = wr_d2_msg;
  assign q_pop[0]  = rd_req_valid && (mode == MODE_DIAG1);
  assign q_pop[1]  = rd_req_valid && (mode == MODE_DIAG2);

  for (genvar g = 0; g < N_DIAG; g++) begin : g_diag
    localparam int unsigned DEP = (g == 0) ? D1_DEPTH : D2_DEPTH;
    cmsg_diag_fifo #(.DEPTH(DEP), .W(MSG_W)) fifo_i (
      .clk(clk), .rst_n(rst_n),
      .push(q_push[g]), .push_data(q_in[g]),
      .pop(q_pop[g]), .head(q_head[g]),
      .empty(q_empty[g]), .err(q_err[g])
    );
  end

  assign err_d1 = q_err[0];
  assign err_d2 = q_err[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ready     <= 1'b0;
      rd_req_ready <= 1'b0;
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
    end else begin
      wr_ready     <= 1'b1;
      rd_req_ready <= 1'b1;
      rd_rsp_valid <= rd_req_valid;
      if (!rd_req_valid) begin
        rd_rsp_data <= '0;
      end else begin
        unique case (mode)
          MODE_DIAG1: rd_rsp_data <= q_empty[0] ? '0 : q_head[0];
          MODE_DIAG2: rd_rsp_data <= q_empty[1] ? '0 : q_head[1];
          default:    rd_rsp_data <= norm_msg;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmsg_store_chk.sv
module cmsg_store_chk #(
  parameter int unsigned MSG_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_d1_en,
  input logic             wr_d2_en,
  input logic             rd_req_valid,
  input logic [1:0]       rd_mode,
  input logic             rd_rsp_valid,
  input logic [MSG_W-1:0] rd_rsp_data,
  input logic             err_d1,
  input logic             err_d2
);
  p_rsp_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |=> rd_rsp_valid);
  p_no_spurious_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_valid |=> !rd_rsp_valid);
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rsp_valid |-> (rd_rsp_data == '0));
  p_sticky_d1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_d1 |=> err_d1);
  p_sticky_d2_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_d2 |=> err_d2);
  p_err_cause_d1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_d1) |-> $past((wr_valid && wr_d1_en) || (rd_req_valid && rd_mode == 2'b01)));
  p_err_cause_d2_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_d2) |-> $past((wr_valid && wr_d2_en) || (rd_req_valid && rd_mode == 2'b10)));
endmodule

bind cmsg_store cmsg_store_chk #(.MSG_W(MSG_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .wr_valid(wr_valid), .wr_d1_en(wr_d1_en), .wr_d2_en(wr_d2_en),
  .rd_req_valid(rd_req_valid), .rd_mode(rd_mode),
  .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
  .err_d1(err_d1), .err_d2(err_d2)
);

// File: tb/cmsg_store_tb_top.sv
`timescale 1ns/1ps
module cmsg_store_tb_top;
  localparam int ROWS = 16, DEG = 8, MAG_W = 5, DEPTH = 8;
  localparam int ROW_W = 4, EDGE_W = 3, MSG_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              wr_valid = 0, wr_d1_en = 0, wr_d2_en = 0;
  logic              wr_ready, rd_req_ready;
  logic [ROW_W-1:0]  wr_row = 0, rd_row = 0;
  logic [MAG_W-1:0]  wr_min1 = 0, wr_min2 = 0;
  logic [EDGE_W-1:0] wr_min_pos = 0, rd_edge = 0;
  logic [DEG-1:0]    wr_signs = 0;
  logic [MSG_W-1:0]  wr_d1_msg = 0, wr_d2_msg = 0;
  logic              rd_req_valid = 0;
  logic [1:0]        rd_mode = 0;
  logic              rd_rsp_valid, err_d1, err_d2;
  logic [MSG_W-1:0]  rd_rsp_data;

  cmsg_store #(.ROWS(ROWS), .DEG(DEG), .MAG_W(MAG_W), .D1_DEPTH(DEPTH), .D2_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_row(wr_row),
    .wr_min1(wr_min1), .wr_min2(wr_min2), .wr_min_pos(wr_min_pos), .wr_signs(wr_signs),
    .wr_d1_en(wr_d1_en), .wr_d1_msg(wr_d1_msg), .wr_d2_en(wr_d2_en), .wr_d2_msg(wr_d2_msg),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_row(rd_row), .rd_edge(rd_edge), .rd_mode(rd_mode),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .err_d1(err_d1), .err_d2(err_d2)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic logic [MSG_W-1:0] expect_msg(logic [MAG_W-1:0] m1, logic [MAG_W-1:0] m2,
      logic [EDGE_W-1:0] p, logic [DEG-1:0] s, logic [EDGE_W-1:0] e);
    int v;
    v = (e == p) ? int'(m2) : int'(m1);
    if (s[e]) v = -v;
    return MSG_W'(v);
  endfunction

  task automatic wr(logic [ROW_W-1:0] row, logic [MAG_W-1:0] m1, logic [MAG_W-1:0] m2,
      logic [EDGE_W-1:0] p, logic [DEG-1:0] s, logic e1, logic [MSG_W-1:0] v1,
      logic e2, logic [MSG_W-1:0] v2);
    @(negedge clk);
    wr_valid = 1; wr_row = row; wr_min1 = m1; wr_min2 = m2; wr_min_pos = p; wr_signs = s;
    wr_d1_en = e1; wr_d1_msg = v1; wr_d2_en = e2; wr_d2_msg = v2;
    @(posedge clk); #1;
    wr_valid = 0; wr_d1_en = 0; wr_d2_en = 0;
  endtask

  task automatic rd(logic [ROW_W-1:0] row, logic [EDGE_W-1:0] e, logic [1:0] m,
      output logic [MSG_W-1:0] d, output logic v);
    @(negedge clk);
    rd_req_valid = 1; rd_row = row; rd_edge = e; rd_mode = m;
    @(posedge clk); #1;
    d = rd_rsp_data; v = rd_rsp_valid;
    rd_req_valid = 0;
  endtask

  task automatic t_reset();
    check("R1 rsp_valid", rd_rsp_valid, 0);
    check("R1 rsp_data", rd_rsp_data, 0);
    check("R1 err_d1", err_d1, 0);
    check("R1 err_d2", err_d2, 0);
    check("R1 wr_ready", wr_ready, 1);
    check("R1 rd_req_ready", rd_req_ready, 1);
  endtask

  task automatic t_normal();
    logic [MSG_W-1:0] d; logic v;
    wr(4'd2, 5'd3, 5'd9, 3'd5, 8'b1010_0110, 0, 0, 0, 0);
    for (int e = 0; e < DEG; e++) begin
      rd(4'd2, 3'(e), 2'b00, d, v);
      if (e == 5) check("R3 min position edge", d, expect_msg(3, 9, 5, 8'b1010_0110, 3'(e)));
      else        check("R2 other edge", d, expect_msg(3, 9, 5, 8'b1010_0110, 3'(e)));
    end
    rd(4'd2, 3'd1, 2'b11, d, v);
    check("R2 mode 11 as normal", d, expect_msg(3, 9, 5, 8'b1010_0110, 3'd1));
    wr(4'd7, 5'd31, 5'd31, 3'd0, 8'hFF, 0, 0, 0, 0);
    rd(4'd7, 3'd0, 2'b00, d, v);
    check("R3 max magnitude negative", d, expect_msg(31, 31, 0, 8'hFF, 3'd0));
    rd(4'd2, 3'd5, 2'b00, d, v);
    check("R12 row 2 after row 7 write", d, expect_msg(3, 9, 5, 8'b1010_0110, 3'd5));
  endtask

  task automatic t_latency();
    logic [MSG_W-1:0] d; logic v;
    rd(4'd2, 3'd0, 2'b00, d, v);
    check("R4 rsp valid next cycle", v, 1);
    @(posedge clk); #1;
    check("R4 valid drops", rd_rsp_valid, 0);
    check("R4 idle data zero", rd_rsp_data, 0);
  endtask

  task automatic t_diag_order();
    logic [MSG_W-1:0] d; logic v;
    wr(4'd1, 5'd1, 5'd2, 3'd0, 8'h00, 0, 0, 1, 6'h3B);
    wr(4'd1, 5'd1, 5'd2, 3'd0, 8'h00, 1, 6'h05, 1, 6'h12);
    wr(4'd1, 5'd1, 5'd2, 3'd0, 8'h00, 1, 6'h2A, 0, 0);
    rd(4'd0, 3'd0, 2'b01, d, v); check("R5 d1 first", d, 6'h05);
    rd(4'd0, 3'd0, 2'b10, d, v); check("R6 d2 first", d, 6'h3B);
    rd(4'd0, 3'd0, 2'b01, d, v); check("R5 d1 second", d, 6'h2A);
    rd(4'd0, 3'd0, 2'b10, d, v); check("R6 d2 second", d, 6'h12);
    check("R6 no error", {err_d1, err_d2}, 0);
  endtask

  task automatic t_enable_gate();
    logic [MSG_W-1:0] d; logic v;
    wr(4'd9, 5'd4, 5'd6, 3'd2, 8'h01, 1, 6'h11, 0, 0);
    wr(4'd9, 5'd7, 5'd8, 3'd3, 8'h00, 0, 6'h22, 0, 6'h33);
    wr(4'd9, 5'd7, 5'd8, 3'd3, 8'h00, 1, 6'h0C, 0, 0);
    rd(4'd9, 3'd3, 2'b00, d, v); check("R7 record written", d, expect_msg(7, 8, 3, 8'h00, 3'd3));
    rd(4'd0, 3'd0, 2'b01, d, v); check("R7 d1 head", d, 6'h11);
    rd(4'd0, 3'd0, 2'b01, d, v); check("R7 disabled push skipped", d, 6'h0C);
    check("R7 no error", {err_d1, err_d2}, 0);
  endtask

  task automatic t_same_cycle();
    logic [MSG_W-1:0] d; logic v;
    wr(4'd3, 5'd10, 5'd12, 3'd1, 8'h00, 0, 0, 0, 0);
    @(negedge clk);
    wr_valid = 1; wr_row = 4'd3; wr_min1 = 5'd2; wr_min2 = 5'd4; wr_min_pos = 3'd6; wr_signs = 8'h04;
    rd_req_valid = 1; rd_row = 4'd3; rd_edge = 3'd2; rd_mode = 2'b00;
    @(posedge clk); #1;
    wr_valid = 0; rd_req_valid = 0;
    check("R11 old record", rd_rsp_data, expect_msg(10, 12, 1, 8'h00, 3'd2));
    rd(4'd3, 3'd2, 2'b00, d, v);
    check("R11 new record after", d, expect_msg(2, 4, 6, 8'h04, 3'd2));
  endtask

  task automatic t_overflow();
    logic [MSG_W-1:0] d; logic v;
    for (int i = 0; i <= DEPTH; i++) begin
      wr(4'd0, 0, 0, 0, 0, 1, 6'(i + 1), 0, 0);
      if (i < DEPTH) check("R8 no error before full", err_d1, 0);
    end
    check("R8 overflow flag", err_d1, 1);
    check("R8 other queue clean", err_d2, 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd(4'd0, 3'd0, 2'b01, d, v);
      check("R8 contents intact", d, 6'(i + 1));
    end
    check("R10 d1 stays set", err_d1, 1);
  endtask

  task automatic t_underflow();
    logic [MSG_W-1:0] d; logic v;
    rd(4'd0, 3'd0, 2'b10, d, v);
    check("R9 empty read valid", v, 1);
    check("R9 empty read zero", d, 0);
    check("R9 flag set", err_d2, 1);
    wr(4'd0, 0, 0, 0, 0, 0, 0, 1, 6'h15);
    rd(4'd0, 3'd0, 2'b10, d, v);
    check("R10 queue still usable", d, 6'h15);
    check("R10 d2 stays set", err_d2, 1);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_normal();
    t_latency();
    t_diag_order();
    t_enable_gate();
    t_same_cycle();
    t_overflow();
    t_underflow();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule